// File: doc/BRIEF.md
# Quad-I/O NAND Fast-Read Responder

This block is the device-side serial engine for a quad-I/O fast-read command of a serial NAND-style memory. A host drives chip select, a serial clock and four data lines. The block runs on its own system clock and passes the serial clock, chip select and data lines through synchronizers. It takes an 8-bit opcode on IO0 and a 16-bit column address as four nibbles. After a fixed run of dummy clocks it drives page-buffer bytes back as nibbles on all four lines. Input bits are taken on rising serial-clock edges and output nibbles change on falling ones, so both idle-low and idle-high clock polarities work.

A mode input picks what happens at the end of the page buffer. In buffer mode the read starts at the received column and the lines float after the last byte. In continuous mode the read starts at byte zero. At the end of the buffer the block asks the surrounding logic for the next page and goes on from that page's byte zero, so one command can stream the whole array. The page buffer is read through a synchronous port with one cycle of latency. A write-protect-enable input blocks the command entirely.

The serial clock must run at no more than one eighth of the system clock.

Top module: `qnr_quad_read_resp`

## Requirements
- R1: The command is accepted only if the 8 bits taken MSB first from io_in[0] on the first 8 rising sck edges after cs_n falls equal 0xEC. Any other value keeps io_oe at 0 until cs_n rises.
- R2: When wpe is 1 at the 8th opcode bit, a 0xEC command is ignored and io_oe stays 0 for the rest of the transaction.
- R3: The column address is taken from io_in[3:0] on the next 4 rising edges, most significant nibble first. In buffer mode (buf_mode=1) the first byte output is the byte at that column.
- R4: io_oe stays 0 through the opcode, address and 10 dummy clocks. The first data nibble is driven (io_oe=4'hF) from the falling edge that follows the 10th dummy rising edge.
- R5: Each byte goes out as two nibbles, bits [7:4] first, on consecutive falling edges, with io_out[3] carrying the nibble MSB.
- R6: In buffer mode bytes advance up to index PAGE_BYTES-1. At the next falling edge io_oe returns to 0 and stays 0 until cs_n rises. A column of PAGE_BYTES or more leaves io_oe at 0 from the start.
- R7: In continuous mode (buf_mode=0) output begins at byte 0 whatever column was sent. After byte PAGE_BYTES-1, pg_req is raised and held until pg_ack. Output then goes on with byte 0 of the new page with no extra clock.
- R8: If a byte has not been loaded when its nibble is due, io_out is 4'hF and underrun goes to 1. underrun stays 1 until the next falling edge of cs_n or reset.
- R9: cs_n high aborts at any time. Within 3 clk cycles io_oe is 0 and pg_req is 0, and the next transaction runs normally.
- R10: After reset io_oe=0, pg_req=0, rd_en=0 and underrun=0.
- R11: Buffer reads present rd_addr with a one-cycle rd_en pulse, always below PAGE_BYTES. rd_data is taken one clk cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wpe | input | 1 | Write-protect-enable status bit; 1 blocks the command |
| buf_mode | input | 1 | 1 = stop at buffer end, 0 = roll into the next page |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Chip select, active low |
| io_in | input | 4 | Serial data lines as seen at the pads |
| io_out | output | 4 | Nibble driven onto the data lines |
| io_oe | output | 4 | Per-line output enable, 0 = high impedance |
| rd_en | output | 1 | Page-buffer read strobe |
| rd_addr | output | COL_W | Page-buffer byte index |
| rd_data | input | 8 | Page-buffer byte, valid the cycle after rd_en |
| pg_req | output | 1 | Request to load the next page |
| pg_ack | input | 1 | Next page loaded |
| underrun | output | 1 | Sticky flag: a nibble was due before its byte |

## Verification
A serial-clock falling edge shows up on io_out and io_oe within 3 clk cycles: two synchronizer stages and one output register. The bench holds each half serial period for 4 clk cycles and samples the outputs on the clk falling edge just before it raises sck. Each sample therefore reflects exactly the previous falling edge, and the first data sample is the one taken in the first clock after the tenth dummy. After a chip-select rise the release is due within 3 cycles, and the bench checks it after 5. At a page rollover the next byte must be loaded within the 8 clk cycles before the following falling edge. The bench acknowledges after one cycle for the normal case and after twenty to force an underrun.

// File: rtl/qnr_pkg.sv
package qnr_pkg;
  typedef enum logic [2:0] {
    FE_IDLE,
    FE_CMD,
    FE_ADDR,
    FE_DUMMY,
    FE_DATA,
    FE_SINK
  } fe_state_t;

  localparam logic [7:0] QNR_OPC_QREAD = 8'hEC;
endpackage

// File: rtl/qnr_sync.sv
module qnr_sync #(
  parameter int STAGES = 2,
  parameter int IO_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sck,
  input  logic            cs_n,
  input  logic [IO_W-1:0] io_in,
  output logic            sck_rise,
  output logic            sck_fall,
  output logic            cs_act,
  output logic            cs_fall,
  output logic [IO_W-1:0] io_s
);
  localparam int NIN = IO_W + 2;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] synced;
  logic           sck_d;
  logic           cs_act_d;

  assign raw = {cs_n, sck, io_in};

  genvar g;
  generate
    for (g = 0; g < NIN; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= (g == NIN - 1) ? '1 : '0;
        else     chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      cs_act_d <= 1'b0;
    end else begin
      sck_d    <= synced[IO_W];
      cs_act_d <= cs_act;
    end
  end

  assign io_s     = synced[IO_W-1:0];
  assign cs_act   = ~synced[NIN-1];
  assign sck_rise = synced[IO_W] & ~sck_d & cs_act;
  assign sck_fall = ~synced[IO_W] & sck_d & cs_act;
  assign cs_fall  = cs_act & ~cs_act_d;
endmodule

// File: rtl/qnr_cmd_front.sv
module qnr_cmd_front
  import qnr_pkg::*;
#(
  parameter int DUMMY_CLKS = 10,
  parameter int OPC_BITS   = 8,
  parameter int COL_NIBS   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_act,
  input  logic                  sck_rise,
  input  logic [3:0]            io_s,
  input  logic                  wpe,
  output logic                  start,
  output logic [4*COL_NIBS-1:0] col_out,
  output logic                  drive_en
);
  localparam int CNT_MAX = (DUMMY_CLKS > OPC_BITS) ? DUMMY_CLKS : OPC_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int COL_W16 = 4 * COL_NIBS;

  fe_state_t            st;
  logic [CNT_W-1:0]     cnt;
  logic [OPC_BITS-2:0]  opc_sh;
  logic [COL_W16-5:0]   col_sh;
  logic [OPC_BITS-1:0]  opc_full;

  assign opc_full = {opc_sh, io_s[0]};
  assign drive_en = (st == FE_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FE_IDLE;
      cnt     <= '0;
      opc_sh  <= '0;
      col_sh  <= '0;
      col_out <= '0;
      start   <= 1'b0;
    end else begin
      start <= 1'b0;
      if (!cs_act) begin
        st  <= FE_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          FE_IDLE: begin
            st  <= FE_CMD;
            cnt <= '0;
          end
          FE_CMD: if (sck_rise) begin
            opc_sh <= opc_full[OPC_BITS-2:0];
            if (cnt == CNT_W'(OPC_BITS - 1)) begin
              cnt <= '0;
              st  <= (opc_full == QNR_OPC_QREAD && !wpe) ? FE_ADDR : FE_SINK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FE_ADDR: if (sck_rise) begin
            col_sh <= {col_sh[COL_W16-9:0], io_s};
            if (cnt == CNT_W'(COL_NIBS - 1)) begin
              cnt     <= '0;
              col_out <= {col_sh, io_s};
              start   <= 1'b1;
              st      <= FE_DUMMY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FE_DUMMY: if (sck_rise) begin
            if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
              cnt <= '0;
              st  <= FE_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= st;
        endcase
      end
    end
  end

  // R1
  sink_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == FE_SINK && cs_act) |=> (st == FE_SINK));
  // R2
  wpe_block_chk: assert property (@(posedge clk) disable iff (rst)
    (st == FE_CMD && cs_act && sck_rise && wpe) |=> (st != FE_ADDR));
endmodule

// File: rtl/qnr_data_eng.sv
module qnr_data_eng #(
  parameter int PAGE_BYTES = 2112,
  parameter int COL_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [15:0]      col_in,
  input  logic             buf_mode,
  input  logic             drive_en,
  input  logic             sck_fall,
  input  logic             abort,
  input  logic             cs_fall,
  output logic             rd_en,
  output logic [COL_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             pg_req,
  input  logic             pg_ack,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             underrun
);
  localparam logic [COL_W-1:0] LAST = COL_W'(PAGE_BYTES - 1);

  logic [COL_W-1:0] col_q;
  logic [7:0]       cur_q;
  logic             byte_ok;
  logic             rd_vld;
  logic             lo_q;
  logic             done_q;
  logic             bufm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      cur_q    <= '0;
      byte_ok  <= 1'b0;
      rd_vld   <= 1'b0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      lo_q     <= 1'b0;
      done_q   <= 1'b0;
      bufm_q   <= 1'b0;
      pg_req   <= 1'b0;
      io_out   <= '0;
      io_oe    <= '0;
      underrun <= 1'b0;
    end else begin
      rd_en  <= 1'b0;
      rd_vld <= rd_en;
      if (rd_vld) begin
        cur_q   <= rd_data;
        byte_ok <= 1'b1;
      end
      if (cs_fall) underrun <= 1'b0;
      if (abort) begin
        io_oe   <= '0;
        pg_req  <= 1'b0;
        done_q  <= 1'b0;
        byte_ok <= 1'b0;
        lo_q    <= 1'b0;
        rd_vld  <= 1'b0;
      end else if (start) begin
        bufm_q  <= buf_mode;
        lo_q    <= 1'b0;
        byte_ok <= 1'b0;
        pg_req  <= 1'b0;
        if (buf_mode && (int'(col_in) >= PAGE_BYTES)) begin
          done_q <= 1'b1;
        end else begin
          done_q  <= 1'b0;
          col_q   <= buf_mode ? col_in[COL_W-1:0] : '0;
          rd_addr <= buf_mode ? col_in[COL_W-1:0] : '0;
          rd_en   <= 1'b1;
        end
      end else begin
        if (pg_req && pg_ack) begin
          pg_req  <= 1'b0;
          rd_addr <= '0;
          rd_en   <= 1'b1;
        end
        if (drive_en && sck_fall) begin
          if (done_q) begin
            io_oe <= '0;
          end else if (!byte_ok) begin
            io_oe    <= 4'hF;
            io_out   <= 4'hF;
            underrun <= 1'b1;
          end else begin
            io_oe  <= 4'hF;
            io_out <= lo_q ? cur_q[3:0] : cur_q[7:4];
            lo_q   <= ~lo_q;
            if (lo_q) begin
              byte_ok <= 1'b0;
              if (col_q == LAST) begin
                if (bufm_q) begin
                  done_q <= 1'b1;
                end else begin
                  col_q  <= '0;
                  pg_req <= 1'b1;
                end
              end else begin
                col_q   <= col_q + 1'b1;
                rd_addr <= col_q + 1'b1;
                rd_en   <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  // R6
  done_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && drive_en && sck_fall && !abort && !start) |=> (io_oe == 4'h0));
  // R7
  pg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pg_req && !pg_ack && !abort && !start) |=> pg_req);
  // R8
  urun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun && !cs_fall) |=> underrun);
  // R9
  abort_rel_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (io_oe == 4'h0 && !pg_req));
  // R11
  rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr <= LAST));
  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);
endmodule

// File: rtl/qnr_quad_read_resp.sv
module qnr_quad_read_resp #(
  parameter int PAGE_BYTES  = 2112,
  parameter int DUMMY_CLKS  = 10,
  parameter int SYNC_STAGES = 2,
  parameter int COL_W       = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wpe,
  input  logic             buf_mode,
  input  logic             sck,
  input  logic             cs_n,
  input  logic [3:0]       io_in,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             rd_en,
  output logic [COL_W-1:0] rd_addr,
  input  logic [7:0]       rd_data,
  output logic             pg_req,
  input  logic             pg_ack,
  output logic             underrun
);
  logic        sck_rise;
  logic        sck_fall;
  logic        cs_act;
  logic        cs_fall;
  logic [3:0]  io_s;
  logic        start;
  logic [15:0] col_rx;
  logic        drive_en;

  qnr_sync #(.STAGES(SYNC_STAGES), .IO_W(4)) sync_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .io_in(io_in),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_fall(cs_fall), .io_s(io_s)
  );

  qnr_cmd_front #(.DUMMY_CLKS(DUMMY_CLKS), .OPC_BITS(8), .COL_NIBS(4)) front_i (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise),
    .io_s(io_s), .wpe(wpe), .start(start), .col_out(col_rx),
    .drive_en(drive_en)
  );

  qnr_data_eng #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) data_i (
    .clk(clk), .rst(rst), .start(start), .col_in(col_rx),
    .buf_mode(buf_mode), .drive_en(drive_en), .sck_fall(sck_fall),
    .abort(~cs_act), .cs_fall(cs_fall), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .pg_req(pg_req), .pg_ack(pg_ack),
    .io_out(io_out), .io_oe(io_oe), .underrun(underrun)
  );

  // R4
  quiet_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> (io_oe == 4'h0));
  // R5
  all_lines_chk: assert property (@(posedge clk) disable iff (rst)
    (io_oe == 4'h0) || (io_oe == 4'hF));
endmodule

// File: tb/qnr_quad_read_resp_tb_top.sv
`timescale 1ns/1ps
module qnr_quad_read_resp_tb_top;
  localparam int P     = 16;
  localparam int COL_W = $clog2(P);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wpe = 1'b0;
  logic             buf_mode = 1'b1;
  logic             sck = 1'b0;
  logic             cs_n = 1'b1;
  logic [3:0]       io_in = 4'h0;
  logic [3:0]       io_out;
  logic [3:0]       io_oe;
  logic             rd_en;
  logic [COL_W-1:0] rd_addr;
  logic [7:0]       rd_data = 8'h00;
  logic             pg_req;
  logic             pg_ack = 1'b0;
  logic             underrun;

  int nchk = 0;
  int nerr = 0;
  int page_id = 0;
  int ack_cnt = 0;
  int ack_dly = 1;
  int rd_bad = 0;
  logic [3:0] nib_q [0:63];
  logic [3:0] oe_q  [0:63];
  logic       pre_oe;

  always #4 clk = ~clk;

  qnr_quad_read_resp #(.PAGE_BYTES(P)) dut_i (
    .clk(clk), .rst(rst), .wpe(wpe), .buf_mode(buf_mode), .sck(sck),
    .cs_n(cs_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pg_req(pg_req), .pg_ack(pg_ack), .underrun(underrun)
  );

  function automatic logic [7:0] exp_byte(input int pg, input int a);
    return 8'((a * 37 + pg * 101 + 90) & 255);
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= exp_byte(page_id, int'(rd_addr));
      if (int'(rd_addr) >= P) rd_bad++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (pg_req && !pg_ack) begin
        repeat (ack_dly) @(negedge clk);
        if (pg_req) begin
          pg_ack = 1'b1;
          page_id++;
          ack_cnt++;
          @(negedge clk);
          pg_ack = 1'b0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] d, output logic [3:0] q, output logic [3:0] o);
    io_in = d;
    repeat (4) @(negedge clk);
    q = io_out;
    o = io_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic end_cs(input bit m3);
    if (m3) begin
      repeat (4) @(negedge clk);
      sck = 1'b1;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] opc, input logic [15:0] col, input bit m3,
                      input int nn, input bit keep_cs);
    logic [3:0] q;
    logic [3:0] o;
    sck = m3;
    page_id = 0;
    pre_oe = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    if (m3) sck = 1'b0;
    for (int i = 0; i < 8; i++) begin
      cyc({3'b000, opc[7-i]}, q, o);
      pre_oe = pre_oe | (|o);
    end
    for (int i = 0; i < 4; i++) begin
      cyc(col[15-4*i -: 4], q, o);
      pre_oe = pre_oe | (|o);
    end
    for (int i = 0; i < 10; i++) begin
      cyc(4'h0, q, o);
      pre_oe = pre_oe | (|o);
    end
    for (int k = 0; k < nn; k++) begin
      cyc(4'h0, q, o);
      nib_q[k] = q;
      oe_q[k]  = o;
    end
    if (!keep_cs) end_cs(m3);
  endtask

  task automatic check_bytes(input string tag, input int k0, input int nb, input int a0);
    for (int b = 0; b < nb; b++) begin
      int a = (a0 + b) % P;
      int pg = (a0 + b) / P;
      logic [7:0] e = exp_byte(pg, a);
      chk(nib_q[k0+2*b] == e[7:4] && oe_q[k0+2*b] == 4'hF, tag, int'(nib_q[k0+2*b]), int'(e[7:4]));
      chk(nib_q[k0+2*b+1] == e[3:0] && oe_q[k0+2*b+1] == 4'hF, tag, int'(nib_q[k0+2*b+1]), int'(e[3:0]));
    end
  endtask

  task automatic t_reset();
    chk(io_oe == 4'h0, "R10 oe", int'(io_oe), 0);
    chk(!pg_req && !rd_en, "R10 req/rd", int'({pg_req, rd_en}), 0);
    chk(!underrun, "R10 underrun", int'(underrun), 0);
  endtask

  task automatic t_buffer_end();
    buf_mode = 1'b1;
    xfer(8'hEC, 16'd12, 1'b0, 10, 1'b0);
    chk(!pre_oe, "R4 hi-Z before data", int'(pre_oe), 0);
    check_bytes("R3 R5 buffer bytes from column", 0, 4, 12);
    chk(oe_q[8] == 4'h0 && oe_q[9] == 4'h0, "R6 hi-Z after last byte",
        int'({oe_q[8], oe_q[9]}), 0);
  endtask

  task automatic t_mode3();
    buf_mode = 1'b1;
    xfer(8'hEC, 16'd3, 1'b1, 4, 1'b0);
    check_bytes("R3 mode 3 read", 0, 2, 3);
  endtask

  task automatic t_col_over();
    buf_mode = 1'b1;
    xfer(8'hEC, 16'h0100, 1'b0, 3, 1'b0);
    chk(oe_q[0] == 4'h0 && oe_q[2] == 4'h0, "R6 column past end",
        int'({oe_q[0], oe_q[2]}), 0);
  endtask

  task automatic t_bad_opc();
    buf_mode = 1'b1;
    xfer(8'hEB, 16'd0, 1'b0, 4, 1'b0);
    chk(oe_q[0] == 4'h0 && oe_q[3] == 4'h0, "R1 wrong opcode", int'(oe_q[0]), 0);
  endtask

  task automatic t_wpe();
    buf_mode = 1'b1;
    wpe = 1'b1;
    xfer(8'hEC, 16'd0, 1'b0, 4, 1'b0);
    wpe = 1'b0;
    chk(oe_q[0] == 4'h0 && oe_q[3] == 4'h0, "R2 write protect", int'(oe_q[0]), 0);
  endtask

  task automatic t_continuous();
    int a0 = ack_cnt;
    buf_mode = 1'b0;
    ack_dly = 1;
    xfer(8'hEC, 16'd5, 1'b0, 2 * P + 4, 1'b0);
    check_bytes("R7 continuous rollover", 0, P + 2, 0);
    chk(ack_cnt == a0 + 1, "R7 one page request", ack_cnt - a0, 1);
    chk(!underrun, "R8 no underrun on time", int'(underrun), 0);
  endtask

  task automatic t_underrun();
    buf_mode = 1'b0;
    ack_dly = 20;
    xfer(8'hEC, 16'd0, 1'b0, 2 * P + 1, 1'b0);
    chk(nib_q[2*P] == 4'hF && oe_q[2*P] == 4'hF, "R8 late page nibble",
        int'(nib_q[2*P]), 15);
    chk(underrun == 1'b1, "R8 sticky after cs", int'(underrun), 1);
    ack_dly = 1;
    buf_mode = 1'b1;
    xfer(8'hEC, 16'd1, 1'b0, 2, 1'b0);
    chk(underrun == 1'b0, "R8 cleared by new cs", int'(underrun), 0);
    check_bytes("R8 read after underrun", 0, 1, 1);
  endtask

  task automatic t_abort();
    buf_mode = 1'b0;
    ack_dly = 40;
    xfer(8'hEC, 16'd0, 1'b0, 2 * P + 1, 1'b1);
    chk(pg_req == 1'b1, "R7 request pending", int'(pg_req), 1);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(io_oe == 4'h0 && !pg_req, "R9 abort release", int'({io_oe, pg_req}), 0);
    repeat (50) @(negedge clk);
    ack_dly = 1;
    buf_mode = 1'b1;
    xfer(8'hEC, 16'd7, 1'b0, 4, 1'b0);
    check_bytes("R9 read after abort", 0, 2, 7);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_buffer_end();
    t_mode3();
    t_col_over();
    t_bad_opc();
    t_wpe();
    t_continuous();
    t_underrun();
    t_abort();
    chk(rd_bad == 0, "R11 read index in range", rd_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule